// File: doc/BRIEF.md
# Reset Cause Capture and Boot Remap Control

This block is a small piece of system control that sits on a single-cycle register port. It records which event caused the latest system reset and keeps that record across the reset itself. Software reads the record back and clears it when it is done with it. A register bit lets software force a system-wide reset. A second control bit selects whether flash or SRAM is decoded at address zero.

The block has four reset sources: the power-on event, a watchdog expiry pulse, an external reset pin and the software request. All four are merged into one active-low system reset request. Only the power-on event reinitialises the cause record. A watchdog or software reset therefore stays visible to boot code after the reset it caused. When the record reads zero, the last reset came from the external pin. Every kind of reset returns the address-zero mapping to flash. Two configuration pins report reduced memory sizes through the remap register.

The register map uses word offsets on a 2-bit address. Offset 0 is the remap register, offset 1 is the cause/status register, offset 2 is the write-only clear register, and offset 3 is unmapped. Writes take effect at the clock edge on which the write strobe is high. Reads are combinational from the address.

Top module: `rcc_top`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is low. After `por_n` has been low for a clock edge, the status register (offset 1) reads 0x01, the remap register (offset 0) control bit reads 0 and `remap_sram` is 0.
- R2: A clock cycle with `wdt_expire` high drives `sys_rst_n` low in that same cycle. It also sets status bit 1, visible after that edge, and leaves the other flags unchanged.
- R3: While `ext_rst_n` is low, `sys_rst_n` is low. The external pin changes no status flag, so a status of 0x00 after clearing identifies an external reset.
- R4: Writing a value with bit 2 set to offset 1 sets status bit 2. It also drives `sys_rst_n` low for exactly `SW_PULSE_CYC` cycles (default 2), starting right after the write edge. Written bits 0, 1 and 7:3 of offset 1 are ignored and cause no reset.
- R5: Writing to offset 2 clears each status flag whose bit (0 power-on, 1 watchdog, 2 software) is 1 in the written data, and leaves the other flags unchanged. Offset 2 always reads 0x00.
- R6: If a watchdog event and a clear write fall in the same cycle, the watchdog flag ends up set. The clear still applies to the other bits.
- R7: Remap bit 0 (offset 0) is written by software, reads back the written value and drives `remap_sram`. Every reset (power-on, external, watchdog or software) returns it to 0.
- R8: Remap bit 4 reads `cfg_small_flash` and bit 3 reads `cfg_small_sram`. Remap bits 7:5 and 2:1 read 0.
- R9: Status bits 7:3 read 0, and offset 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on event, active low, synchronous; also the block's own reset |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_expire | input | 1 | Watchdog expiry pulse, active high |
| cfg_small_flash | input | 1 | Configuration pin: reduced flash size |
| cfg_small_sram | input | 1 | Configuration pin: reduced SRAM size |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| sys_rst_n | output | 1 | Combined system reset request, active low |
| remap_sram | output | 1 | 1 maps SRAM at address zero, 0 maps flash |

## Verification
The outputs follow two kinds of timing. Read data and `sys_rst_n` for the pin, watchdog and power-on sources are combinational, so they are sampled one nanosecond after the inputs are driven, within the same cycle. Flag, remap and clear effects become visible after the next rising edge, and they are sampled one nanosecond after that edge. The software reset appears after the write edge and is sampled once in each of the `SW_PULSE_CYC` cycles that follow, and again in the cycle after that to confirm that it has been released. The clear and priority sweeps cover every flag state against every clear value, and the expected values are computed by masking in the bench.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets and bit positions for the reset-cause block.
// Assumes a 2-bit word offset on the register port.
package rcc_pkg;
    typedef enum logic [1:0] {
        OFS_REMAP  = 2'd0,
        OFS_CAUSE  = 2'd1,
        OFS_CLEAR  = 2'd2,
        OFS_UNUSED = 2'd3
    } rcc_ofs_e;

    localparam int FLAG_N      = 3;
    localparam int BIT_POR     = 0;
    localparam int BIT_WDT     = 1;
    localparam int BIT_SW      = 2;
    localparam int BIT_MAP     = 0;
    localparam int BIT_SMSRAM  = 3;
    localparam int BIT_SMFLASH = 4;
    localparam logic [FLAG_N-1:0] FLAGS_AT_POR = 3'b001;
endpackage

// File: rtl/rcc_cause_flags.sv
`timescale 1ns/1ps
// Module: sticky reset-cause flag storage.
// Only the power-on input reinitialises the flags. Set requests beat
// clear requests on the same bit in the same cycle.
module rcc_cause_flags
    import rcc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic [FLAG_N-1:0] clr_vec,
    output logic [FLAG_N-1:0] flags
);
    // Flag update: power-on load, else clear then set (set wins).
    always_ff @(posedge clk) begin
        if (!por_n) flags <= FLAGS_AT_POR;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_chk
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
            set_vec[i] |=> flags[i]);
        // R5
        clear_bit_chk: assert property (@(posedge clk) disable iff (!por_n)
            (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
        // R3
        hold_bit_chk: assert property (@(posedge clk) disable iff (!por_n)
            (!clr_vec[i] && !set_vec[i]) |=> $stable(flags[i]));
    end
endmodule

// File: rtl/rcc_sw_pulse.sv
`timescale 1ns/1ps
// Module: stretches a one-cycle software reset trigger into a reset pulse
// of PULSE_CYC cycles, starting the cycle after the trigger edge.
// Assumes PULSE_CYC >= 1. A new trigger during a pulse reloads it.
module rcc_sw_pulse #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic trigger,
    output logic active
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    logic [CW-1:0] cnt;

    // Countdown: load on trigger, then decrement to zero.
    always_ff @(posedge clk) begin
        if (!por_n)          cnt <= '0;
        else if (trigger)    cnt <= CW'(PULSE_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

    // R4
    sw_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        trigger |=> active);
    if (PULSE_CYC >= 2) begin : g_len
        // R4
        sw_min_len_chk: assert property (@(posedge clk) disable iff (!por_n)
            $rose(active) |=> active);
    end
endmodule

// File: rtl/rcc_remap_bit.sv
`timescale 1ns/1ps
// Module: boot remap control bit. Any reset source returns it to 0
// (flash at address zero). Reset has priority over a write.
module rcc_remap_bit (
    input  logic clk,
    input  logic por_n,
    input  logic any_rst,
    input  logic wr_en,
    input  logic wr_val,
    output logic sel
);
    // Remap state: cleared by any reset, else loaded by a write.
    always_ff @(posedge clk) begin
        if (!por_n || any_rst) sel <= 1'b0;
        else if (wr_en)        sel <= wr_val;
    end

    // R7
    remap_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        any_rst |=> !sel);
    // R7
    remap_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !any_rst) |=> (sel == $past(wr_val)));
endmodule

// File: rtl/rcc_top.sv
`timescale 1ns/1ps
// Module: reset-cause capture and boot remap control, top level.
// Merges the reset sources into sys_rst_n, keeps sticky cause flags, decodes
// the register port and returns combinational read data.
// Assumes DATA_W >= 5 and a single-cycle register port.
module rcc_top
    import rcc_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SW_PULSE_CYC = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              wdt_expire,
    input  logic              cfg_small_flash,
    input  logic              cfg_small_sram,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_rst_n,
    output logic              remap_sram
);
    logic              wr_remap, wr_cause, wr_clear;
    logic              sw_trig, sw_active, any_rst;
    logic [FLAG_N-1:0] set_vec, clr_vec, flags;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:FLAG_N];

    // Write decode for the three mapped registers.
    always_comb begin
        wr_remap = reg_wr && (reg_addr == OFS_REMAP);
        wr_cause = reg_wr && (reg_addr == OFS_CAUSE);
        wr_clear = reg_wr && (reg_addr == OFS_CLEAR);
    end

    assign sw_trig = wr_cause && reg_wdata[BIT_SW];

    // Set and clear vectors for the flag store.
    always_comb begin
        set_vec          = '0;
        set_vec[BIT_WDT] = wdt_expire;
        set_vec[BIT_SW]  = sw_trig;
        clr_vec          = wr_clear ? reg_wdata[FLAG_N-1:0] : '0;
    end

    rcc_cause_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    rcc_sw_pulse #(.PULSE_CYC(SW_PULSE_CYC)) u_swp (
        .clk     (clk),
        .por_n   (por_n),
        .trigger (sw_trig),
        .active  (sw_active)
    );

    // Non-power-on reset sources, merged.
    assign any_rst   = !ext_rst_n || wdt_expire || sw_active;
    assign sys_rst_n = por_n && !any_rst;

    rcc_remap_bit u_remap (
        .clk     (clk),
        .por_n   (por_n),
        .any_rst (any_rst),
        .wr_en   (wr_remap),
        .wr_val  (reg_wdata[BIT_MAP]),
        .sel     (remap_sram)
    );

    // Read mux: unmapped offsets and reserved bits read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_REMAP: begin
                reg_rdata[BIT_MAP]     = remap_sram;
                reg_rdata[BIT_SMSRAM]  = cfg_small_sram;
                reg_rdata[BIT_SMFLASH] = cfg_small_flash;
            end
            OFS_CAUSE: reg_rdata[FLAG_N-1:0] = flags;
            default:   reg_rdata = '0;
        endcase
    end

    // R2
    wdt_to_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_expire |-> !sys_rst_n);
    // R3
    pin_to_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_n |-> !sys_rst_n);
endmodule

// File: tb/sim_rcc_top.sv
`timescale 1ns/1ps
module sim_rcc_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, ext_rst_n = 1'b1, wdt_expire = 1'b0;
    logic       cfg_small_flash = 1'b0, cfg_small_sram = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sys_rst_n, remap_sram;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [2:0] exp_flags;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    rcc_top #(.DATA_W(8), .SW_PULSE_CYC(2)) u0 (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_expire(wdt_expire),
        .cfg_small_flash(cfg_small_flash), .cfg_small_sram(cfg_small_sram),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n), .remap_sram(remap_sram)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // advance to 1 ns after the next rising edge
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic do_por();
        por_n = 1'b0; step(); por_n = 1'b1; exp_flags = 3'b001;
    endtask

    task automatic do_wdt();
        wdt_expire = 1'b1; step(); wdt_expire = 1'b0; exp_flags[1] = 1'b1;
    endtask

    task automatic do_sw();
        bus_wr(2'd1, 8'h04); step(); step(); exp_flags[2] = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: power-on state
        #1;
        step(); #1;
        chk("R1 sys_rst_n during por", sys_rst_n, 0);
        step(); por_n = 1'b1; exp_flags = 3'b001;
        bus_rd(2'd1, rv); chk("R1 status after por", rv, 8'h01);
        bus_rd(2'd0, rv); chk("R1 remap after por", rv, 8'h00);
        chk("R1 remap_sram after por", remap_sram, 0);
        chk("R1 sys_rst_n released", sys_rst_n, 1);

        // R9 unmapped offset, R5 clear register reads zero
        bus_rd(2'd3, rv); chk("R9 offset 3 reads zero", rv, 0);
        bus_rd(2'd2, rv); chk("R5 clear reg reads zero", rv, 0);

        // R8: configuration pins sweep, with remap bit both ways
        for (int k = 0; k < 8; k++) begin
            cfg_small_flash = k[2]; cfg_small_sram = k[1];
            bus_wr(2'd0, {7'd0, k[0]});
            bus_rd(2'd0, rv);
            chk("R8 remap register read", rv, {3'd0, k[2], k[1], 2'd0, k[0]});
            chk("R7 remap_sram follows write", remap_sram, k[0]);
        end
        cfg_small_flash = 1'b0; cfg_small_sram = 1'b0;

        // R7: each reset source returns remap to 0
        for (int src = 0; src < 4; src++) begin
            bus_wr(2'd0, 8'h01);
            chk("R7 remap set", remap_sram, 1);
            case (src)
                0: do_por();
                1: begin ext_rst_n = 1'b0; step(); ext_rst_n = 1'b1; end
                2: do_wdt();
                default: do_sw();
            endcase
            chk("R7 remap cleared by reset", remap_sram, 0);
            bus_rd(2'd0, rv); chk("R7 remap read after reset", rv, 0);
        end

        // R3: external pin leaves flags alone
        do_por(); bus_wr(2'd2, 8'h07); exp_flags = 0;
        ext_rst_n = 1'b0; #1;
        chk("R3 sys_rst_n low on pin", sys_rst_n, 0);
        step(); ext_rst_n = 1'b1;
        bus_rd(2'd1, rv); chk("R3 status zero means external", rv, 0);
        do_wdt();
        ext_rst_n = 1'b0; step(); ext_rst_n = 1'b1;
        bus_rd(2'd1, rv); chk("R3 pin keeps wdt flag", rv, 8'h02);

        // R2: watchdog
        bus_wr(2'd2, 8'h07); exp_flags = 0;
        wdt_expire = 1'b1; #1;
        chk("R2 sys_rst_n low on wdt", sys_rst_n, 0);
        step(); wdt_expire = 1'b0;
        bus_rd(2'd1, rv); chk("R2 wdt flag set", rv, 8'h02);

        // R4: software reset
        bus_wr(2'd2, 8'h07);
        bus_wr(2'd1, 8'hFB);
        chk("R4 other bits cause no reset", sys_rst_n, 1);
        step(); chk("R4 still no reset", sys_rst_n, 1);
        bus_rd(2'd1, rv); chk("R4 other bits ignored", rv, 0);
        bus_wr(2'd1, 8'h04);
        chk("R4 pulse cycle 1", sys_rst_n, 0);
        step(); chk("R4 pulse cycle 2", sys_rst_n, 0);
        step(); chk("R4 pulse released", sys_rst_n, 1);
        bus_rd(2'd1, rv); chk("R4 sw flag set", rv, 8'h04);
        chk("R9 status upper bits zero", rv[7:3], 0);

        // R5: every flag state against every clear value
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 8; c++) begin
                do_por();
                if (s[1]) do_wdt();
                if (s[2]) do_sw();
                bus_wr(2'd2, {5'd0, ~s[2:0]});
                bus_wr(2'd2, c[7:0] | 8'hF8);
                bus_rd(2'd1, rv);
                chk("R5 clear sweep", rv, {5'd0, s[2:0] & ~c[2:0]});
            end
        end

        // R6: watchdog event beats a same-cycle clear
        for (int c = 0; c < 8; c++) begin
            do_por(); do_sw();
            wdt_expire = 1'b1;
            bus_wr(2'd2, c[7:0]);
            wdt_expire = 1'b0;
            bus_rd(2'd1, rv);
            chk("R6 set beats clear", rv, {5'd0, (3'b101 & ~c[2:0]) | 3'b010});
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule